// File: doc/BRIEF.md
# Serial Port Register Front-End

This block is the bus-facing register bank of a byte-oriented serial port. A simple word-addressed bus (read and write strobes, byte address, 32-bit data) reaches four registers: a receive data port, a transmit data port, a read-only status word and a control word. On the line side, an upstream serial engine pushes received bytes over a byte-wide valid/ready stream. The bank offers one transmit byte at a time to a downstream engine over a valid/ready handshake.

Received bytes wait in an 8-entry FIFO until software drains them through the receive data port. If a byte arrives while the FIFO is full, it is refused and lost. A sticky pending flag is raised when the FIFO holds data and when software writes the transmit port. A single level interrupt is the pending flag gated by an enable bit in the control word. Bit-level serialisation, baud timing and line error detection belong to the engines on either side. The status bits that would report those errors always read as zero.

Register data reads are combinational from the current state while the read strobe is high. All state changes take effect at the following rising clock edge.

Top module: `sio_regfront`

## Requirements
- R1: After a synchronous active-low reset, the receive FIFO is empty, the control word is zero, the pending flag is clear and tx_valid is low. Status reads 0x04 and irq is low.
- R2: The register index is bus_addr shifted right by 2. Index 0 reads receive data, index 1 takes transmit writes, index 2 is status and index 3 is control. Reads of index 1 and of any index of 4 or above return 0. Writes to indices of 4 or above change nothing.
- R3: Status bit map: bit0 = FIFO non-empty, bit1 = FIFO holds 8 bytes, bit2 = no transmit byte outstanding, bit3 = transmit byte outstanding, bit4 = pending flag. Bits 5 to 31 read 0.
- R4: The receive FIFO holds 8 bytes and returns them in arrival order. rx_ready is high exactly when fewer than 8 bytes are held. A byte offered while the FIFO is full is discarded.
- R5: A read of index 0 returns the oldest byte in bits 7:0 and removes it. A read while the FIFO is empty returns the byte in the slot at the read position (stale data) and leaves the FIFO empty.
- R6: An accepted receive byte and a receive-data read in the same cycle both take effect, so the count does not change.
- R7: A control write stores all 32 bits, and they read back at index 3. If bit1 of the written value is 1, the FIFO is emptied and any byte accepted in that cycle is discarded.
- R8: A transmit write places bits 7:0 on tx_byte and raises tx_valid. tx_valid and tx_byte hold until a cycle with tx_ready high. Transmit writes made while a byte is outstanding are ignored.
- R9: The pending flag is set when the FIFO will be non-empty after the edge, and on every transmit write. A control write sets the flag to whether the FIFO is non-empty after that write. Nothing else clears the flag.
- R10: irq is high exactly when the pending flag and control bit4 are both 1.
- R11: Writes to the status index (2) change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| rx_byte | input | 8 | Received byte from the serial engine |
| rx_valid | input | 1 | rx_byte is offered |
| rx_ready | output | 1 | FIFO can take a byte |
| tx_byte | output | 8 | Byte for the serial engine |
| tx_valid | output | 1 | tx_byte is outstanding |
| tx_ready | input | 1 | Serial engine takes tx_byte |
| irq | output | 1 | Level interrupt |

## Verification
The FIFO is checked with a short two-byte burst, a fill to capacity plus one extra byte, and a full drain with one more read past empty. Together these separate in-order delivery, the full boundary, the drop of the ninth byte and the stale read on empty. A push that coincides with a pop tells simultaneous update apart from a lost event. A push that coincides with a receive reset shows that the reset wins. For the pending flag, the test sequence separates stickiness after a drain, clearing by a control write while the FIFO is empty, and setting by a transmit write.

// File: rtl/sio_pkg.sv
// Package: register indices and bit positions shared by the serial port
// front-end and its checker. No logic is held here.
package sio_pkg;

    typedef enum logic [1:0] {
        IDX_RX   = 2'd0,
        IDX_TX   = 2'd1,
        IDX_STAT = 2'd2,
        IDX_CTRL = 2'd3
    } reg_idx_e;

    // status word bit positions (R3)
    localparam int ST_RXV  = 0;
    localparam int ST_RXF  = 1;
    localparam int ST_TXE  = 2;
    localparam int ST_TXF  = 3;
    localparam int ST_PEND = 4;

    // control word bit positions (R7, R10)
    localparam int CT_RST_TX = 0;
    localparam int CT_RST_RX = 1;
    localparam int CT_IE     = 4;

    localparam int NUM_REGS = 4;

endpackage

// File: rtl/sio_rxq.sv
// Module: receive byte queue.
// A circular buffer of DEPTH entries with a write pointer and an occupancy
// count. The read position is derived as write pointer minus count.
// Assumes that DEPTH is a power of two, so the pointer arithmetic wraps naturally.
// A clear empties the queue and overrides a push in the same cycle.
// A pop while the queue is empty is ignored, but dout still shows the slot at the read position.
module sio_rxq #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nx,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr;
    logic [PW-1:0] rptr;
    logic          do_push;
    logic          do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign rptr    = wptr - count[PW-1:0];
    assign dout    = mem[rptr];

    // Next occupancy: clear wins, otherwise push and pop net out.
    always_comb begin
        if (clr)
            count_nx = '0;
        else
            count_nx = count + CW'(do_push) - CW'(do_pop);
    end

    // Storage write; slots are not reset, so stale contents stay visible.
    always_ff @(posedge clk) begin
        if (do_push)
            mem[wptr] <= din;
    end

    // Pointer and count update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr  <= '0;
            count <= '0;
        end else begin
            if (do_push)
                wptr <= wptr + 1'b1;
            count <= count_nx;
        end
    end

endmodule

// File: rtl/sio_txhold.sv
// Module: transmit holding register.
// Holds one outgoing byte and offers it on a valid/ready handshake.
// A load is taken only while nothing is outstanding; a load at any other time is dropped.
// Assumes that the consumer may raise ready at any time. The byte leaves on the first cycle with ready high.
module sio_txhold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] tx_byte,
    output logic         tx_valid,
    input  logic         tx_ready
);

    // Capture a new byte when idle, and release it on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else if (!tx_valid) begin
            if (load) begin
                tx_valid <= 1'b1;
                tx_byte  <= din;
            end
        end else if (tx_ready) begin
            tx_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/sio_regfront.sv
// Module: serial port register front-end (top).
// Decodes a word-addressed register bank over a simple strobe bus.
// Registers: receive data (pop), transmit data (push to holding register),
// status (read-only) and control (stored as written).
// Keeps a sticky pending flag and drives a level interrupt.
// Assumes at most one bus access per cycle. Read data is combinational and valid in the strobe cycle.
module sio_regfront
    import sio_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int RX_DEPTH = 8,
    parameter int BYTE_W   = 8,
    localparam int CW      = $clog2(RX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              irq
);

    logic [ADDR_W-1:0] widx;
    logic              in_map;
    reg_idx_e          sel;
    logic              wr_tx, wr_ctrl, wr_stat, rd_rx, rx_clr;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] stat_w;
    logic              pend;
    logic [BYTE_W-1:0] rx_dout;
    logic [CW-1:0]     rx_cnt, rx_cnt_nx;
    logic              rx_full, rx_empty;

    // Word index decode (R2).
    assign widx    = bus_addr >> 2;
    assign in_map  = (widx < ADDR_W'(NUM_REGS));
    assign sel     = reg_idx_e'(widx[1:0]);
    assign wr_tx   = bus_wr && in_map && (sel == IDX_TX);
    assign wr_ctrl = bus_wr && in_map && (sel == IDX_CTRL);
    assign wr_stat = bus_wr && in_map && (sel == IDX_STAT);
    assign rd_rx   = bus_rd && in_map && (sel == IDX_RX);
    assign rx_clr  = wr_ctrl && bus_wdata[CT_RST_RX];

    sio_rxq #(.DEPTH(RX_DEPTH), .W(BYTE_W)) rxq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (rx_clr),
        .push     (rx_valid),
        .din      (rx_byte),
        .pop      (rd_rx),
        .dout     (rx_dout),
        .count    (rx_cnt),
        .count_nx (rx_cnt_nx),
        .full     (rx_full),
        .empty    (rx_empty)
    );

    assign rx_ready = !rx_full;

    sio_txhold #(.W(BYTE_W)) txh_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_tx),
        .din      (bus_wdata[BYTE_W-1:0]),
        .tx_byte  (tx_byte),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready)
    );

    // Control word: stored exactly as written (R7).
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= bus_wdata;
    end

    // Sticky pending flag: set by occupancy and transmit writes, re-evaluated by control writes (R9).
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (wr_ctrl)
            pend <= (rx_cnt_nx != '0);
        else
            pend <= pend || (rx_cnt_nx != '0) || wr_tx;
    end

    // Status word assembly; line error bits stay zero (R3).
    always_comb begin
        stat_w          = '0;
        stat_w[ST_RXV]  = !rx_empty;
        stat_w[ST_RXF]  = rx_full;
        stat_w[ST_TXE]  = !tx_valid;
        stat_w[ST_TXF]  = tx_valid;
        stat_w[ST_PEND] = pend;
    end

    // Read data multiplexer (R2, R5).
    always_comb begin
        bus_rdata = '0;
        if (in_map) begin
            unique case (sel)
                IDX_RX:   bus_rdata = DATA_W'(rx_dout);
                IDX_TX:   bus_rdata = '0;
                IDX_STAT: bus_rdata = stat_w;
                IDX_CTRL: bus_rdata = ctrl_q;
            endcase
        end
    end

    // Interrupt gate (R10).
    assign irq = pend && ctrl_q[CT_IE];

endmodule

// File: rtl/sio_regfront_chk.sv
// Module: property checker for the serial port front-end, attached by bind.
// Observes the top-level ports and the internal decode strobes. It drives nothing.
module sio_regfront_chk #(
    parameter int DEPTH  = 8,
    parameter int CW     = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic [CW-1:0]     rx_cnt,
    input logic              rd_rx,
    input logic              rx_clr,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_byte,
    input logic              pend,
    input logic              wr_ctrl,
    input logic              wr_stat,
    input logic [DATA_W-1:0] ctrl_q,
    input logic              irq
);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= CW'(DEPTH));

    // R4
    full_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt == CW'(DEPTH)) |-> !rx_ready);

    // R6
    push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_ready && rd_rx && rx_cnt != '0 && !rx_clr) |=> rx_cnt == $past(rx_cnt));

    // R7
    rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr |=> rx_cnt == '0);

    // R8
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    // R9
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !wr_ctrl) |=> pend);

    // R10
    irq_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend && ctrl_q[4]));

    // R11
    stat_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat |=> $stable(ctrl_q));

endmodule

bind sio_regfront sio_regfront_chk #(
    .DEPTH  (RX_DEPTH),
    .CW     (CW),
    .DATA_W (DATA_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_cnt   (rx_cnt),
    .rd_rx    (rd_rx),
    .rx_clr   (rx_clr),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_byte  (tx_byte),
    .pend     (pend),
    .wr_ctrl  (wr_ctrl),
    .wr_stat  (wr_stat),
    .ctrl_q   (ctrl_q),
    .irq      (irq)
);

// File: tb/sio_regfront_test.sv
// Bench: table-driven register sequence followed by directed corner tests.
module sio_regfront_test;

    localparam int ADDR_W = 8;
    localparam int NROWS  = 18;
    localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_PUSH = 2'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  tx_byte;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [31:0] got;

    always #4 clk = ~clk;

    sio_regfront #(.ADDR_W(ADDR_W)) uut (
        .clk, .rst_n, .bus_rd, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
        .rx_byte, .rx_valid, .rx_ready, .tx_byte, .tx_valid, .tx_ready, .irq
    );

    // Row layout: {req[7:0], kind[1:0], idx[3:0], data[31:0], expect[31:0]}
    localparam logic [77:0] TBL [NROWS] = '{
        {8'd3,  K_RD,   4'd2, 32'h0,     32'h04},  // R3 idle status
        {8'd4,  K_PUSH, 4'd0, 32'hA1,    32'h0},
        {8'd4,  K_PUSH, 4'd0, 32'hB2,    32'h0},
        {8'd9,  K_RD,   4'd2, 32'h0,     32'h15},  // R9 pend with data
        {8'd5,  K_RD,   4'd0, 32'h0,     32'hA1},  // R5 oldest first
        {8'd5,  K_RD,   4'd0, 32'h0,     32'hB2},
        {8'd9,  K_RD,   4'd2, 32'h0,     32'h14},  // R9 sticky after drain
        {8'd9,  K_WR,   4'd3, 32'h10,    32'h0},
        {8'd7,  K_RD,   4'd3, 32'h0,     32'h10},  // R7 readback
        {8'd9,  K_RD,   4'd2, 32'h0,     32'h04},  // R9 cleared by ctrl write
        {8'd11, K_WR,   4'd2, 32'hFF,    32'h0},
        {8'd11, K_RD,   4'd3, 32'h0,     32'h10},  // R11 ctrl untouched
        {8'd11, K_RD,   4'd2, 32'h0,     32'h04},  // R11 status untouched
        {8'd2,  K_WR,   4'd5, 32'h55,    32'h0},
        {8'd2,  K_RD,   4'd5, 32'h0,     32'h0},   // R2 out of map
        {8'd2,  K_RD,   4'd1, 32'h0,     32'h0},   // R2 tx index reads 0
        {8'd8,  K_WR,   4'd1, 32'h1C3,   32'h0},
        {8'd3,  K_RD,   4'd2, 32'h0,     32'h18}   // R3 tx outstanding
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // One bus cycle with optional simultaneous receive push; rdata sampled before the edge.
    task automatic cyc(input logic rd, input logic wr, input int idx, input logic [31:0] d,
                       input logic pv, input logic [7:0] pb);
        @(negedge clk);
        bus_rd    = rd;
        bus_wr    = wr;
        bus_addr  = ADDR_W'(idx << 2);
        bus_wdata = d;
        rx_valid  = pv;
        rx_byte   = pb;
        #2;
        got = bus_rdata;
        @(posedge clk);
        #1;
        bus_rd   = 1'b0;
        bus_wr   = 1'b0;
        rx_valid = 1'b0;
    endtask

    task automatic rd_reg(input int idx);
        cyc(1'b1, 1'b0, idx, 32'h0, 1'b0, 8'h0);
    endtask

    task automatic wr_reg(input int idx, input logic [31:0] d);
        cyc(1'b0, 1'b1, idx, d, 1'b0, 8'h0);
    endtask

    task automatic push(input logic [7:0] b);
        cyc(1'b0, 1'b0, 0, 32'h0, 1'b1, b);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        @(negedge clk);
        check("R1 rx_ready", 32'(rx_ready), 32'h1);
        check("R1 tx_valid", 32'(tx_valid), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        rd_reg(2); check("R1 status", got, 32'h04);
        rd_reg(3); check("R1 ctrl", got, 32'h0);

        // Table walk
        for (int i = 0; i < NROWS; i++) begin
            logic [77:0] row;
            row = TBL[i];
            case (row[69:68])
                K_RD:   rd_reg(int'(row[67:64]));
                K_WR:   wr_reg(int'(row[67:64]), row[63:32]);
                default: push(row[39:32]);
            endcase
            if (row[69:68] == K_RD) begin
                n_chk++;
                if (got !== row[31:0]) begin
                    n_bad++;
                    $display("FAIL R%0d row %0d actual=0x%0h expected=0x%0h",
                             row[77:70], i, got, row[31:0]);
                end
            end
        end

        // R8 outstanding byte, R10 irq with IE set and pending
        @(negedge clk);
        check("R8 tx_valid", 32'(tx_valid), 32'h1);
        check("R8 tx_byte", 32'(tx_byte), 32'hC3);
        check("R10 irq on", 32'(irq), 32'h1);
        wr_reg(1, 32'h77);
        @(negedge clk);
        check("R8 second write ignored", 32'(tx_byte), 32'hC3);
        tx_ready = 1'b1;
        @(posedge clk); #1; tx_ready = 1'b0;
        @(negedge clk);
        check("R8 released", 32'(tx_valid), 32'h0);
        rd_reg(2); check("R8 status idle", got, 32'h14);

        // R10 gating and R9 clear/set
        wr_reg(3, 32'h0);
        @(negedge clk); check("R10 irq off", 32'(irq), 32'h0);
        wr_reg(3, 32'h10);
        @(negedge clk); check("R9 pend cleared, irq low", 32'(irq), 32'h0);
        push(8'h5A);
        @(negedge clk); check("R9 push sets pend irq", 32'(irq), 32'h1);
        rd_reg(0); check("R5 pop", got, 32'h5A);
        @(negedge clk); check("R9 sticky irq", 32'(irq), 32'h1);
        wr_reg(3, 32'h10);

        // R4 fill to capacity and one extra
        for (int k = 0; k < 9; k++) push(8'(8'h10 + k));
        @(negedge clk); check("R4 ready low when full", 32'(rx_ready), 32'h0);
        rd_reg(2); check("R3 full status", got, 32'h17);
        for (int k = 0; k < 8; k++) begin
            rd_reg(0); check("R4 order", got, 32'(8'h10 + k));
        end
        rd_reg(0); check("R5 stale read", got, 32'h10);
        rd_reg(2); check("R5 count stays zero", got, 32'h14);

        // R6 simultaneous push and pop
        push(8'h61);
        cyc(1'b1, 1'b0, 0, 32'h0, 1'b1, 8'h62);
        check("R6 pop data", got, 32'h61);
        rd_reg(2); check("R6 one left", got, 32'h15);
        rd_reg(0); check("R6 pushed byte", got, 32'h62);
        rd_reg(2); check("R6 empty", got, 32'h14);

        // R7 receive reset with same-cycle push
        push(8'h71); push(8'h72); push(8'h73);
        cyc(1'b0, 1'b1, 3, 32'h02, 1'b1, 8'h74);
        rd_reg(2); check("R7 emptied, pend cleared", got, 32'h04);
        rd_reg(3); check("R7 stored as written", got, 32'h02);
        push(8'h75);
        rd_reg(0); check("R7 pointer restarted", got, 32'h75);

        // R9 control write with data present keeps pend
        push(8'h81);
        wr_reg(3, 32'h10);
        @(negedge clk); check("R9 pend kept with data", 32'(irq), 32'h1);

        // R1 reset mid-activity
        wr_reg(1, 32'h99);
        do_reset();
        @(negedge clk);
        check("R1 irq after reset", 32'(irq), 32'h0);
        check("R1 tx_valid after reset", 32'(tx_valid), 32'h0);
        rd_reg(2); check("R1 status after reset", got, 32'h04);
        rd_reg(3); check("R1 ctrl after reset", got, 32'h0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule